// File: doc/BRIEF.md
# Pipelined Float-to-Integer Converter

This block turns a 32-bit single-precision binary floating-point operand into a 32-bit signed two's-complement integer. The caller picks one of four rounding directions for each operand. Operands enter and results leave through valid/ready stream ports, and a result comes with two flags. One flag marks an operand that has no integer representation. The other marks a conversion that dropped nonzero fraction bits.

The datapath has three register stages. The first stage restores the hidden bit and shifts the significand right by an amount taken from the exponent, which yields the integer magnitude plus guard, round and sticky bits. It also spots operands that must saturate. The second stage builds two candidates side by side: the magnitude XORed with the sign, and that same value plus one. A rounding decision then selects one of them. A positive operand therefore gets its magnitude or its magnitude plus one. A negative operand gets the two's complement of the rounded magnitude, so no separate negation step is needed. The third stage applies saturation and drives the output registers.

Back-pressure: the whole pipeline moves forward on a clock edge when the output register is empty or the sink asserts `out_ready`. `in_ready` reflects exactly that condition. An operand is taken on an edge where `in_valid` and `in_ready` are both high. A result leaves on an edge where `out_valid` and `out_ready` are both high. While the sink holds `out_ready` low, the output holds its value.

Top module: `fti_conv`

## Requirements
- R1: Stream ports obey valid/ready. An operand accepted on edge k shows its result from edge k+2 when the sink never stalls. Results come out in acceptance order. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and both flags hold steady.
- R2: A finite operand whose value is an integer in the signed 32-bit range converts exactly, in every mode, with `out_inexact` low.
- R3: When `in_mode` = 2'b00 (nearest, ties to even), the magnitude rises by one when the first discarded bit is 1 and either the kept LSB or any lower discarded bit is 1.
- R4: When `in_mode` = 2'b01 (toward zero), the magnitude is always truncated.
- R5: When `in_mode` = 2'b10 (toward +infinity), a positive operand with discarded bits rounds up. When `in_mode` = 2'b11 (toward -infinity), a negative operand with discarded bits rounds its magnitude up. In every other case these two modes truncate.
- R6: A negative operand yields the two's complement of its rounded magnitude. A negative value whose magnitude rounds to zero yields 0.
- R7: An operand of magnitude below 0.5 (including subnormals and zeros) yields magnitude 0 or 1 as the mode and sign dictate.
- R8: A NaN gives 0x7FFFFFFF with `out_invalid` high. +infinity gives 0x7FFFFFFF and -infinity gives 0x80000000, both with `out_invalid` high.
- R9: A finite operand of magnitude 2^31 or more saturates to 0x7FFFFFFF (positive) or 0x80000000 (negative) with `out_invalid` high. The single exception is exactly -2^31, which gives 0x80000000 with no flag.
- R10: `out_inexact` is high exactly when a finite in-range conversion discarded a nonzero fraction. It is low whenever `out_invalid` is high.
- R11: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Pipeline can take an operand this cycle |
| in_data | input | 32 | Single-precision operand |
| in_mode | input | 2 | Rounding direction: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink takes the result this cycle |
| out_data | output | 32 | Signed integer result |
| out_invalid | output | 1 | Operand not representable (NaN, infinity, out of range) |
| out_inexact | output | 1 | Nonzero fraction was discarded |

## Verification
A result is due two clock edges after the edge that accepted its operand, and only later when the sink stalls. Since stalls move that point, the bench does not count a fixed latency. At each acceptance it pushes the independently computed expected word and flags into a queue. It pops and compares one entry at every edge where `out_valid` and `out_ready` are both high. All sampling happens shortly after the falling edge, once inputs have settled. While the sink is stalled, the bench also compares the output against what it showed one cycle earlier.

// File: rtl/fti_pkg.sv
package fti_pkg;
  localparam int INT_W  = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;

  localparam int SIG_W  = FRAC_W + 1;
  localparam int FP_W   = 1 + EXP_W + FRAC_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int T_W    = 2 * INT_W;
  localparam int SH_W   = $clog2(INT_W + 1);
  localparam int E_TOP  = BIAS + INT_W - 1;
  localparam int E_LOW  = BIAS - 1;

  localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;

  typedef struct packed {
    logic             neg;
    logic [INT_W-1:0] mag;
    logic             g;
    logic             r;
    logic             sy;
    rmode_e           mode;
    logic             force_en;
    logic             force_inv;
    logic [INT_W-1:0] force_val;
  } align_t;

  typedef struct packed {
    logic [INT_W-1:0] val;
    logic             inx;
    logic             force_en;
    logic             force_inv;
    logic [INT_W-1:0] force_val;
  } round_t;

  // Decide whether the magnitude is bumped by one.
  function automatic logic bump(input rmode_e m, input logic neg, input logic lsb,
                                input logic g, input logic r, input logic sy);
    logic lost;
    lost = g | r | sy;
    case (m)
      RM_NEAR: bump = g & (lsb | r | sy);
      RM_ZERO: bump = 1'b0;
      RM_UP:   bump = ~neg & lost;
      default: bump = neg & lost;
    endcase
  endfunction
endpackage

// File: rtl/fti_align.sv
module fti_align
  import fti_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            vld_i,
  input  logic [FP_W-1:0] op_i,
  input  rmode_e          mode_i,
  output logic            vld_q,
  output align_t          q
);
  localparam logic [EXP_W-1:0] E_TOP_V = EXP_W'(E_TOP);
  localparam logic [EXP_W-1:0] E_LOW_V = EXP_W'(E_LOW);

  logic              sign;
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic [SIG_W-1:0]  sig;
  logic              exp_max, big, tiny, nonzero, min_exact;
  logic [EXP_W-1:0]  sh_full;
  logic [SH_W-1:0]   sh;
  logic [T_W-1:0]    wide, shifted;
  align_t            nxt;

  always_comb begin
    sign      = op_i[FP_W-1];
    expo      = op_i[FP_W-2:FRAC_W];
    frac      = op_i[FRAC_W-1:0];
    exp_max   = &expo;
    nonzero   = |op_i[FP_W-2:0];
    sig       = {|expo, frac};
    big       = (expo >= E_TOP_V);
    tiny      = (expo < E_LOW_V);
    min_exact = sign && (expo == E_TOP_V) && (frac == '0);
    sh_full   = E_TOP_V - expo;
    sh        = sh_full[SH_W-1:0];
    wide      = {sig, {(T_W-SIG_W){1'b0}}};
    shifted   = wide >> sh;

    nxt           = '0;
    nxt.neg       = sign;
    nxt.mode      = mode_i;
    if (exp_max || big) begin
      nxt.force_en  = 1'b1;
      nxt.force_inv = ~min_exact;
      if (exp_max && (frac != '0)) nxt.force_val = POS_SAT;
      else                         nxt.force_val = sign ? NEG_SAT : POS_SAT;
    end else if (tiny) begin
      nxt.sy = nonzero;
    end else begin
      nxt.mag = shifted[T_W-1:INT_W];
      nxt.g   = shifted[INT_W-1];
      nxt.r   = shifted[INT_W-2];
      nxt.sy  = |shifted[INT_W-3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  vld_q <= 1'b0;
    else if (en) vld_q <= vld_i;
  end

  always_ff @(posedge clk) begin
    if (en) q <= nxt;
  end
endmodule

// File: rtl/fti_round.sv
module fti_round
  import fti_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   vld_i,
  input  align_t a_i,
  output logic   vld_q,
  output round_t q
);
  logic             up, pick;
  logic [INT_W-1:0] cand_lo, cand_hi;
  round_t           nxt;

  always_comb begin
    up      = bump(a_i.mode, a_i.neg, a_i.mag[0], a_i.g, a_i.r, a_i.sy);
    // Both candidates exist before the decision is known.
    cand_lo = a_i.mag ^ {INT_W{a_i.neg}};
    cand_hi = cand_lo + INT_W'(1);
    // Negative: bump picks the inverse, no bump picks inverse plus one.
    pick    = up ^ a_i.neg;

    nxt           = '0;
    nxt.val       = pick ? cand_hi : cand_lo;
    nxt.inx       = a_i.g | a_i.r | a_i.sy;
    nxt.force_en  = a_i.force_en;
    nxt.force_inv = a_i.force_inv;
    nxt.force_val = a_i.force_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  vld_q <= 1'b0;
    else if (en) vld_q <= vld_i;
  end

  always_ff @(posedge clk) begin
    if (en) q <= nxt;
  end
endmodule

// File: rtl/fti_emit.sv
module fti_emit
  import fti_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             vld_i,
  input  round_t           r_i,
  output logic             vld_q,
  output logic [INT_W-1:0] data_q,
  output logic             inv_q,
  output logic             inx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  vld_q <= 1'b0;
    else if (en) vld_q <= vld_i;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      data_q <= r_i.force_en ? r_i.force_val : r_i.val;
      inv_q  <= r_i.force_en & r_i.force_inv;
      inx_q  <= ~r_i.force_en & r_i.inx;
    end
  end
endmodule

// File: rtl/fti_conv.sv
module fti_conv
  import fti_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FP_W-1:0]  in_data,
  input  logic [1:0]       in_mode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [INT_W-1:0] out_data,
  output logic             out_invalid,
  output logic             out_inexact
);
  logic   adv;
  logic   s1_vld, s2_vld;
  align_t s1_q;
  round_t s2_q;

  assign adv      = ~out_valid | out_ready;
  assign in_ready = adv;

  fti_align u_align (
    .clk(clk), .rst_n(rst_n), .en(adv), .vld_i(in_valid),
    .op_i(in_data), .mode_i(rmode_e'(in_mode)),
    .vld_q(s1_vld), .q(s1_q)
  );

  fti_round u_round (
    .clk(clk), .rst_n(rst_n), .en(adv), .vld_i(s1_vld),
    .a_i(s1_q), .vld_q(s2_vld), .q(s2_q)
  );

  fti_emit u_emit (
    .clk(clk), .rst_n(rst_n), .en(adv), .vld_i(s2_vld),
    .r_i(s2_q), .vld_q(out_valid), .data_q(out_data),
    .inv_q(out_invalid), .inx_q(out_inexact)
  );
endmodule

// File: rtl/fti_conv_chk.sv
module fti_conv_chk
  import fti_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [INT_W-1:0] out_data,
  input logic             out_invalid,
  input logic             out_inexact
);
  a_r1_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  a_r1_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data) && $stable(out_invalid) && $stable(out_inexact));

  a_r8_sat_value: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> (out_data == POS_SAT) || (out_data == NEG_SAT));

  a_r10_invalid_exact: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> !out_inexact);

  a_r11_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

bind fti_conv fti_conv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_invalid(out_invalid), .out_inexact(out_inexact)
);

// File: tb/fti_conv_tb_top.sv
module fti_conv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [31:0] in_data;
  logic [1:0]  in_mode;
  logic        out_valid, out_ready;
  logic [31:0] out_data;
  logic        out_invalid, out_inexact;

  always #5 clk = ~clk;

  fti_conv dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mode(in_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_invalid(out_invalid),
    .out_inexact(out_inexact)
  );

  int total = 0;
  int bad   = 0;

  logic [31:0] q_d[$];
  bit          q_v[$];
  bit          q_x[$];
  string       q_t[$];

  localparam int NDIR  = 18;
  localparam int NRAND = 3000;
  localparam int NVEC  = NDIR * 4 + NRAND;
  localparam int LIMIT = 150000;

  logic [31:0] dir_vals [NDIR] = '{
    32'h40200000, 32'h40600000, 32'hC0200000, 32'hC0600000,
    32'h3E99999A, 32'hBE99999A, 32'h3F000000, 32'h3FC00000,
    32'h7FC00000, 32'h7F800000, 32'hFF800000, 32'h4F000000,
    32'hCF000000, 32'h80000000, 32'h4EFFFFFF, 32'h00000001,
    32'h3F7FFFFF, 32'hCF000001
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  // Behavioural reference: integer arithmetic on the decoded value.
  task automatic ref_conv(input logic [31:0] x, input logic [1:0] m,
                          output logic [31:0] res, output bit inv, output bit inx,
                          output string tag);
    longint sig, ip, rem, half, mag;
    int     e, ue, shift;
    bit     s, up;
    s = x[31];
    e = int'(x[30:23]);
    half = 0;
    rem  = 0;
    if (e == 255) begin
      inv = 1; inx = 0; tag = "R8";
      res = ((x[22:0] != 0) || !s) ? 32'h7FFFFFFF : 32'h80000000;
      return;
    end
    sig = (e != 0) ? (longint'(x[22:0]) + (longint'(1) << 23)) : longint'(x[22:0]);
    ue  = (e == 0) ? -126 : e - 127;
    if (ue >= 31) begin
      inx = 0; tag = "R9";
      if (s && ue == 31 && sig == (longint'(1) << 23)) begin
        inv = 0; res = 32'h80000000;
      end else begin
        inv = 1; res = s ? 32'h80000000 : 32'h7FFFFFFF;
      end
      return;
    end
    if (ue >= 23) begin
      ip = sig << (ue - 23);
    end else begin
      shift = 23 - ue;
      if (shift > 60) shift = 60;
      ip   = sig >> shift;
      rem  = sig - (ip << shift);
      half = longint'(1) << (shift - 1);
    end
    inx = (rem != 0);
    case (m)
      2'b00:   up = inx && ((rem > half) || (rem == half && ip[0]));
      2'b01:   up = 0;
      2'b10:   up = inx && !s;
      default: up = inx && s;
    endcase
    mag = ip + longint'(up);
    if (!s && mag > 64'sd2147483647) begin
      inv = 1; inx = 0; res = 32'h7FFFFFFF;
    end else begin
      inv = 0;
      res = s ? 32'(-mag) : 32'(mag);
    end
    if (ue < -1 && sig != 0) tag = "R7";
    else if (s)              tag = "R6";
    else if (!inx)           tag = "R2";
    else if (m == 2'b00)     tag = "R3";
    else if (m == 2'b01)     tag = "R4";
    else                     tag = "R5";
  endtask

  task automatic gen(input int idx, output logic [31:0] d, output logic [1:0] m);
    if (idx < NDIR * 4) begin
      d = dir_vals[idx / 4];
      m = 2'(idx % 4);
    end else begin
      m = 2'($urandom % 4);
      if ($urandom % 16 == 0) d = $urandom;
      else d = {1'($urandom), 8'(100 + ($urandom % 62)), 23'($urandom)};
    end
  endtask

  initial begin
    int          idx;
    bit          last_fire, hold, done;
    logic [31:0] sv_d, e_d;
    bit          sv_v, sv_x, e_v, e_x;
    string       e_t;
    idx = 0; last_fire = 0; hold = 0; done = 0;
    sv_d = '0; sv_v = 0; sv_x = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_mode = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R11", "out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R11", "in_ready after reset", 32'(in_ready), 32'd1);

    for (int cyc = 0; cyc < LIMIT; cyc++) begin
      @(negedge clk);
      if (hold) begin
        check(out_valid == 1'b1, "R1", "valid during stall", 32'(out_valid), 32'd1);
        check(out_data == sv_d && out_invalid == sv_v && out_inexact == sv_x,
              "R1", "data during stall", out_data, sv_d);
      end
      if (last_fire) idx++;
      if (!in_valid || last_fire) begin
        if (idx < NVEC && ($urandom % 5 != 0)) begin
          in_valid = 1'b1;
          gen(idx, in_data, in_mode);
        end else begin
          in_valid = 1'b0;
        end
      end
      out_ready = ($urandom % 4 != 0);
      if (idx >= NVEC && !in_valid && q_d.size() == 0) begin
        done = 1;
        break;
      end
      #1;
      if (out_valid && out_ready) begin
        if (q_d.size() == 0) begin
          check(1'b0, "R1", "unexpected result", out_data, 32'd0);
        end else begin
          e_d = q_d.pop_front(); e_v = q_v.pop_front();
          e_x = q_x.pop_front(); e_t = q_t.pop_front();
          check(out_data == e_d, e_t, "data", out_data, e_d);
          check(out_invalid == e_v, (e_t == "R9") ? "R9" : "R8", "invalid flag",
                32'(out_invalid), 32'(e_v));
          check(out_inexact == e_x, "R10", "inexact flag", 32'(out_inexact), 32'(e_x));
        end
      end
      hold = out_valid && !out_ready;
      sv_d = out_data; sv_v = out_invalid; sv_x = out_inexact;
      last_fire = in_valid && in_ready;
      if (last_fire) begin
        ref_conv(in_data, in_mode, e_d, e_v, e_x, e_t);
        q_d.push_back(e_d); q_v.push_back(e_v);
        q_x.push_back(e_x); q_t.push_back(e_t);
      end
    end

    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog expired got=%0d exp=%0d", idx, NVEC);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule